// File: doc/BRIEF.md
# Eight-bit ALU with per-operation flag rules

This block is the arithmetic and logic stage of a small accumulator processor. Each accepted request carries an operation code, two 8-bit operands and the incoming condition-code bits. It returns an 8-bit result, the updated condition-code bits, and a write-back flag that says whether the result should be stored.

Every operation has its own rule for each flag. A flag may be computed from the result, forced to 0, forced to 1, or passed through unchanged from the request. The combinational datapath is split into three units: arithmetic, logical, and shift/rotate. Their outputs feed a single output register.

Requests arrive on a valid/ready input and results leave on a valid/ready output. The input is accepted whenever the output register is empty or is being drained in the same cycle. A result that has been presented stays on the outputs, unchanged, until it is taken. Results leave in the order their requests were accepted, one result per request, with one cycle of latency.

Top module: `byte_alu`

## Requirements
- R1: The condition-code vector is {H,N,Z,V,C}, with H in bit 4 and C in bit 0. The operation codes are:
  - 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CMP
  - 5 AND, 6 BIT, 7 OR, 8 EOR, 9 MOV, 10 TST
  - 11 COM, 12 NEG, 13 INC, 14 DEC
  - 15 LSR, 16 LSL, 17 ASR, 18 ROR, 19 ROL, 20 CLR

  out_write is 1 for every operation except CMP, BIT, TST and codes 21 to 31.
- R2: ADD returns a+b and ADC returns a+b+C.
  - H is the carry out of bit 3 and C is the carry out of bit 7.
  - V is set on two's-complement overflow.
  - N is result bit 7 and Z means a zero result.
- R3: SUB and CMP return a-b, and SBC returns a-b-C.
  - C is set when a borrow occurs.
  - V is set on signed overflow.
  - N and Z are computed from the result, and H is passed through unchanged.
- R4: The logical group clears V, computes N and Z, and leaves C and H unchanged:
  - AND and BIT return a&b.
  - OR returns a|b and EOR returns a^b.
  - MOV returns b and TST returns a.
- R5: COM returns ~a, sets C to 1, clears V, computes N and Z, and keeps H.
- R6: NEG returns 0-a.
  - C is 1 when the result is nonzero.
  - V is 1 when the result is 0x80.
  - N and Z are computed, and H is kept.
- R7: INC returns a+1 and DEC returns a-1.
  - V is set on a change from 0x7F to 0x80 (INC) or from 0x80 to 0x7F (DEC).
  - N and Z are computed, and C and H are kept.
- R8: The shift and rotate group works as follows:
  - LSR shifts right and inserts 0.
  - LSL shifts left and inserts 0.
  - ASR shifts right and keeps bit 7.
  - ROR and ROL shift in the incoming C.
  - C takes the bit shifted out.
  - N and Z are computed, V = N xor C, and H is kept. As a result, LSR always yields N = 0.
- R9: CLR returns 0, sets Z, clears N, V and C, and keeps H.
- R10: Codes 21 to 31 return a, pass all five flags through unchanged, and hold out_write low.
- R11: Handshake behaviour:
  - in_ready is high when the output register is empty or out_ready is high.
  - While out_valid is high and out_ready is low, out_result, out_ccr and out_write hold steady.
  - Every accepted request yields exactly one result, in order, one cycle after acceptance.
- R12: While rst_n is low, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when in_valid is also high |
| in_op | input | 5 | Operation code |
| in_a | input | 8 | First operand |
| in_b | input | 8 | Second operand |
| in_ccr | input | 5 | Incoming flags {H,N,Z,V,C} |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Result value |
| out_write | output | 1 | Result should be written back |
| out_ccr | output | 5 | Updated flags {H,N,Z,V,C} |

## Verification
The hardest cases to reach are the single-point flag conditions:
- signed overflow on the exact 0x7F/0x80 boundary for INC, DEC and NEG;
- a half-carry produced only by the incoming carry;
- a borrow caused only by the incoming carry on SBC.

Uniform random operands almost never land on these, so the stimulus adds directed requests for each one. Random operands and random incoming flags then cover both carry values for every code, including the unassigned ones. The consumer withdraws out_ready on random cycles, so back-pressure stalls arrive back-to-back with new requests. This exercises result holding and ordering while the reference queue is deep.

// File: rtl/byte_alu_pkg.sv
`timescale 1ns/1ps
package byte_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_BIT = 5'd6,  OP_OR  = 5'd7,
    OP_EOR = 5'd8,  OP_MOV = 5'd9,  OP_TST = 5'd10, OP_COM = 5'd11,
    OP_NEG = 5'd12, OP_INC = 5'd13, OP_DEC = 5'd14, OP_LSR = 5'd15,
    OP_LSL = 5'd16, OP_ASR = 5'd17, OP_ROR = 5'd18, OP_ROL = 5'd19,
    OP_CLR = 5'd20
  } alu_op_e;

  localparam int unsigned OP_LAST = 20;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_SHIFT = 2'd2,
    UNIT_NONE  = 2'd3
  } unit_e;

  function automatic unit_e unit_of(logic [4:0] op);
    unit_e u;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP,
      OP_NEG, OP_INC, OP_DEC:                  u = UNIT_ARITH;
      OP_AND, OP_BIT, OP_OR, OP_EOR, OP_MOV,
      OP_TST, OP_COM, OP_CLR:                  u = UNIT_LOGIC;
      OP_LSR, OP_LSL, OP_ASR, OP_ROR, OP_ROL:  u = UNIT_SHIFT;
      default:                                 u = UNIT_NONE;
    endcase
    return u;
  endfunction

  function automatic logic keeps_result(logic [4:0] op);
    logic k;
    case (op)
      OP_CMP, OP_BIT, OP_TST: k = 1'b0;
      default:                k = (32'(op) <= OP_LAST);
    endcase
    return k;
  endfunction

endpackage

// File: rtl/byte_alu_arith.sv
`timescale 1ns/1ps
module byte_alu_arith
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  ccr_t         ci,
  output logic [W-1:0] r,
  output ccr_t         co
);
  localparam int HW = W / 2;
  localparam logic [W-1:0] TOP  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXP = ~TOP;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W:0]  wide;
  logic [HW:0] low;
  logic        cx;

  always_comb begin
    co   = ci;
    r    = a;
    wide = '0;
    low  = '0;
    cx   = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        cx   = (op == OP_ADC) && ci.c;
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cx};
        low  = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cx};
        r    = wide[W-1:0];
        co.h = low[HW];
        co.c = wide[W];
        co.v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        cx   = (op == OP_SBC) && ci.c;
        wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cx};
        r    = wide[W-1:0];
        co.c = wide[W];
        co.v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      OP_NEG: begin
        r    = -a;
        co.c = (a != '0);
        co.v = (a == TOP);
      end
      OP_INC: begin
        r    = a + ONE;
        co.v = (a == MAXP);
      end
      OP_DEC: begin
        r    = a - ONE;
        co.v = (a == TOP);
      end
      default: ;
    endcase
    co.n = r[W-1];
    co.z = (r == '0);
  end
endmodule

// File: rtl/byte_alu_logic.sv
`timescale 1ns/1ps
module byte_alu_logic
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  ccr_t         ci,
  output logic [W-1:0] r,
  output ccr_t         co
);
  always_comb begin
    co = ci;
    case (op)
      OP_AND, OP_BIT: r = a & b;
      OP_OR:          r = a | b;
      OP_EOR:         r = a ^ b;
      OP_MOV:         r = b;
      OP_COM:         r = ~a;
      OP_CLR:         r = '0;
      default:        r = a;
    endcase
    co.v = 1'b0;
    if (op == OP_COM) co.c = 1'b1;
    if (op == OP_CLR) co.c = 1'b0;
    co.n = r[W-1];
    co.z = (r == '0);
  end
endmodule

// File: rtl/byte_alu_shift.sv
`timescale 1ns/1ps
module byte_alu_shift
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  ccr_t         ci,
  output logic [W-1:0] r,
  output ccr_t         co
);
  logic fill;
  logic right;

  always_comb begin
    co    = ci;
    right = 1'b1;
    case (op)
      OP_LSR: fill = 1'b0;
      OP_ASR: fill = a[W-1];
      OP_ROR: fill = ci.c;
      OP_LSL: begin fill = 1'b0; right = 1'b0; end
      OP_ROL: begin fill = ci.c; right = 1'b0; end
      default: fill = 1'b0;
    endcase
    if (right) begin
      r    = {fill, a[W-1:1]};
      co.c = a[0];
    end else begin
      r    = {a[W-2:0], fill};
      co.c = a[W-1];
    end
    co.n = r[W-1];
    co.z = (r == '0);
    co.v = co.n ^ co.c;
  end
endmodule

// File: rtl/byte_alu.sv
`timescale 1ns/1ps
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [4:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [4:0]   in_ccr,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_write,
  output logic [4:0]   out_ccr
);
  ccr_t         cc_in;
  logic [W-1:0] r_ar, r_lg, r_sh, r_sel;
  ccr_t         c_ar, c_lg, c_sh, c_sel;
  logic         take;

  assign cc_in = ccr_t'(in_ccr);

  byte_alu_arith #(.W(W)) u_arith (
    .op(in_op), .a(in_a), .b(in_b), .ci(cc_in), .r(r_ar), .co(c_ar));

  byte_alu_logic #(.W(W)) u_logic (
    .op(in_op), .a(in_a), .b(in_b), .ci(cc_in), .r(r_lg), .co(c_lg));

  byte_alu_shift #(.W(W)) u_shift (
    .op(in_op), .a(in_a), .ci(cc_in), .r(r_sh), .co(c_sh));

  always_comb begin
    case (unit_of(in_op))
      UNIT_ARITH: begin r_sel = r_ar; c_sel = c_ar; end
      UNIT_LOGIC: begin r_sel = r_lg; c_sel = c_lg; end
      UNIT_SHIFT: begin r_sel = r_sh; c_sel = c_sh; end
      default:    begin r_sel = in_a; c_sel = cc_in; end
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_write  <= 1'b0;
      out_ccr    <= '0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        out_result <= r_sel;
        out_write  <= keeps_result(in_op);
        out_ccr    <= c_sel;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/byte_alu_chk.sv
`timescale 1ns/1ps
module byte_alu_chk
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [4:0]   in_op,
  input logic [4:0]   in_ccr,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_write,
  input logic [4:0]   out_ccr
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
                                && $stable(out_ccr) && $stable(out_write));

  // R11
  accept_yields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R9
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == OP_CLR |=> out_result == '0 && out_ccr[3:0] == 4'b0100
                               && out_ccr[4] == $past(in_ccr[4]));

  // R5
  com_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == OP_COM |=> out_ccr[0] && !out_ccr[1]);

  // R8
  shift_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op >= OP_LSR && in_op <= OP_ROL
      |=> out_ccr[1] == (out_ccr[3] ^ out_ccr[0]));

  // R8
  lsr_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == OP_LSR |=> !out_ccr[3]);

  // R1
  nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == OP_CMP || in_op == OP_BIT || in_op == OP_TST || in_op > OP_CLR)
      |=> !out_write);

  // R4
  logic_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op >= OP_AND && in_op <= OP_TST
      |=> !out_ccr[1] && out_ccr[0] == $past(in_ccr[0]) && out_ccr[4] == $past(in_ccr[4]));

  // R10
  unknown_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op > OP_CLR |=> out_ccr == $past(in_ccr));

  // R12
  always_comb begin
    if (!rst_n) reset_idle_chk: assert (!out_valid || $isunknown(out_valid));
  end
endmodule

bind byte_alu byte_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_ccr(in_ccr), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_write(out_write), .out_ccr(out_ccr));

// File: tb/byte_alu_bench.sv
`timescale 1ns/1ps
module byte_alu_bench;
  import byte_alu_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [4:0] in_op;
  logic [7:0] in_a, in_b;
  logic [4:0] in_ccr;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_result;
  logic       out_write;
  logic [4:0] out_ccr;

  always #4 clk = ~clk;

  byte_alu u_byte_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_ccr(in_ccr),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_write(out_write), .out_ccr(out_ccr));

  typedef struct {
    logic [4:0] op;
    logic [7:0] r;
    logic       w;
    logic [4:0] f;
  } item_t;

  item_t q[$];
  int  n_tests = 0;
  int  n_fail  = 0;
  bit  bp_on   = 1'b0;
  bit  done    = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic string tag_of(logic [4:0] op);
    if (op <= 5'd1)  return "R2";
    if (op <= 5'd4)  return "R3";
    if (op <= 5'd10) return "R4";
    if (op == 5'd11) return "R5";
    if (op == 5'd12) return "R6";
    if (op <= 5'd14) return "R7";
    if (op <= 5'd19) return "R8";
    if (op == 5'd20) return "R9";
    return "R10";
  endfunction

  function automatic int sgn(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  // Reference: flags f = {H,N,Z,V,C}
  function automatic item_t model(logic [4:0] op, logic [7:0] a8, logic [7:0] b8, logic [4:0] f);
    item_t it;
    int a = a8, b = b8, s = 0, cin = f[0];
    bit h = f[4], n, z, v = f[1], c = f[0], calc_nz = 1;
    it.op = op;
    it.w  = !(op == 5'd4 || op == 5'd6 || op == 5'd10 || op > 5'd20);
    case (op)
      5'd0, 5'd1: begin
        if (op == 5'd0) cin = 0;
        s = a + b + cin;
        h = ((a % 16) + (b % 16) + cin) > 15;
        c = s > 255;
        v = (sgn(a) + sgn(b) + cin > 127) || (sgn(a) + sgn(b) + cin < -128);
      end
      5'd2, 5'd3, 5'd4: begin
        if (op != 5'd3) cin = 0;
        s = a - b - cin;
        c = s < 0;
        v = (sgn(a) - sgn(b) - cin > 127) || (sgn(a) - sgn(b) - cin < -128);
      end
      5'd5, 5'd6: begin s = a & b; v = 0; end
      5'd7:       begin s = a | b; v = 0; end
      5'd8:       begin s = a ^ b; v = 0; end
      5'd9:       begin s = b; v = 0; end
      5'd10:      begin s = a; v = 0; end
      5'd11:      begin s = 255 - a; v = 0; c = 1; end
      5'd12:      begin s = 256 - a; c = (a != 0); v = (a == 128); end
      5'd13:      begin s = a + 1; v = (a == 127); end
      5'd14:      begin s = a - 1; v = (a == 128); end
      5'd15:      begin s = a / 2; c = a % 2; end
      5'd16:      begin s = a * 2; c = a >= 128; end
      5'd17:      begin s = a / 2 + (a >= 128 ? 128 : 0); c = a % 2; end
      5'd18:      begin s = a / 2 + f[0] * 128; c = a % 2; end
      5'd19:      begin s = (a * 2) % 256 + f[0]; c = a >= 128; end
      5'd20:      begin s = 0; v = 0; c = 0; end
      default:    begin s = a; calc_nz = 0; end
    endcase
    s = s & 255;
    n = calc_nz ? (s >= 128) : f[3];
    z = calc_nz ? (s == 0)   : f[2];
    if (op >= 5'd15 && op <= 5'd19) v = n ^ c;
    it.r = s[7:0];
    it.f = {h, n, z, v, c};
    return it;
  endfunction

  task automatic send(logic [4:0] op, logic [7:0] a, logic [7:0] b, logic [4:0] f);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_ccr = f;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    q.push_back(model(op, a, b, f));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    logic       held = 1'b0;
    logic [7:0] hr;
    logic [4:0] hf;
    logic       hw;
    forever begin
      @(negedge clk);
      out_ready = bp_on ? ($urandom_range(3) != 0) : 1'b1;
      #2;
      if (rst_n) begin
        if (held) begin
          // R11 stability under back-pressure
          chk(out_valid && out_result == hr && out_ccr == hf && out_write == hw,
              "R11", "stall hold", {out_valid, out_write, out_ccr, out_result},
              {1'b1, hw, hf, hr});
        end
        held = out_valid && !out_ready;
        hr = out_result; hf = out_ccr; hw = out_write;
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            chk(1'b0, "R11", "unexpected result", 1, 0);
          end else begin
            item_t e;
            e = q.pop_front();
            chk(out_result == e.r, tag_of(e.op), $sformatf("result op=%0d", e.op),
                out_result, e.r);
            chk(out_ccr == e.f, tag_of(e.op), $sformatf("flags op=%0d", e.op),
                out_ccr, e.f);
            chk(out_write == e.w, "R1", $sformatf("write op=%0d", e.op),
                out_write, e.w);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0; in_ccr = '0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    // R12 reset state
    chk(!out_valid, "R12", "out_valid in reset", out_valid, 0);
    chk(in_ready,   "R12", "in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 corners
    send(5'd0, 8'h7F, 8'h01, 5'h00);   // signed overflow and half carry
    send(5'd1, 8'h0F, 8'h00, 5'h01);   // half carry from incoming C only
    send(5'd1, 8'hFF, 8'h00, 5'h01);   // wraps to zero, C and Z
    // R3 corners
    send(5'd2, 8'h80, 8'h01, 5'h10);   // signed overflow, H kept
    send(5'd3, 8'h00, 8'h00, 5'h01);   // borrow from incoming C only
    send(5'd4, 8'h05, 8'h05, 5'h00);   // equal compare, no write
    // R6 / R7 corners
    send(5'd12, 8'h80, 8'h00, 5'h00);
    send(5'd12, 8'h00, 8'h00, 5'h1F);
    send(5'd13, 8'h7F, 8'h00, 5'h01);
    send(5'd14, 8'h80, 8'h00, 5'h00);
    // R8 rotates with both carry values
    send(5'd18, 8'h01, 8'h00, 5'h01);
    send(5'd19, 8'h80, 8'h00, 5'h00);
    send(5'd17, 8'h81, 8'h00, 5'h00);
    // R9 clear keeps H
    send(5'd20, 8'hAA, 8'h55, 5'h1F);
    // R10 unassigned code
    send(5'd25, 8'h3C, 8'hC3, 5'h15);

    // Random sweep over every code with both incoming carry values, under back-pressure
    bp_on = 1'b1;
    for (int op = 0; op < 32; op++) begin
      for (int k = 0; k < 30; k++) begin
        send(op[4:0], 8'($urandom), 8'($urandom), {5'($urandom) & 5'h1E} | 5'(k % 2));
      end
    end

    @(negedge clk);
    in_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    bp_on = 1'b0;
    repeat (3) @(negedge clk);
    // R11 nothing left over and no extra result
    chk(q.size() == 0 && !out_valid, "R11", "drain", q.size(), 0);
    finish_run();
  end
endmodule